// File: doc/BRIEF.md
# Fixed-Point Sigmoid Unit With Interpolated Table

This block evaluates the logistic function 1/(1+e^-x) in integer arithmetic for the activation stage of a neural-network datapath. Each cycle it can accept one signed fixed-point sample, marked by a valid strobe. The block splits the offset input into a coarse index and a 6-bit fraction. The index selects two neighbouring entries of a 65-entry table. The table covers the span from -8 up to +8 at steps of 0.25, and its entries are computed by a constant function during elaboration. The fraction then blends linearly between the two entries.

The result is an 8-bit two's complement code with 7 fraction bits, so the real value is code/128. Inputs below the tabulated span give the bottom table value. Inputs at or above +8 give the largest positive code. The block is a two-stage pipeline with one result per cycle. The first stage reads the table, which is written as a registered dual-read memory. The second stage interpolates and registers the output.

Top module: `sigmoid_lut`

## Requirements
- R1: While the synchronous active-high reset is asserted, out_valid is 0 and out_data is 0. A reset asserted while a sample is in flight cancels that sample's out_valid.
- R2: out_valid in a cycle equals in_valid two clock cycles earlier.
- R3: in_data is signed Q5.8, so x = in_data/256. For every x in [-8, +8), out_data (value out_data/128) is within 2 LSB of 128/(1+e^-x).
- R4: When x lies on a table knot (the low 6 bits of in_data are 0, and -8 <= x < +8), out_data equals round(128/(1+e^-x)), limited to at most 127.
- R5: Inputs with x < -8 give out_data 0, which is the value of the bottom table entry.
- R6: Inputs with x >= +8 give out_data 127.
- R7: Every valid output is non-negative. Over inputs presented in increasing order, successive outputs never decrease.
- R8: While out_valid is 0, out_data holds the last valid result unchanged, whatever in_data does.
- R9: Back-to-back valid inputs produce back-to-back valid outputs, one per cycle, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe for in_data |
| in_data | input | 13 | Signed Q5.8 input sample |
| out_valid | output | 1 | Result strobe |
| out_data | output | 8 | Signed result with 7 fraction bits |

## Verification
Every result is due exactly two rising edges after the edge that captures its input. The first edge loads the table outputs and the second loads the interpolated result. The bench drives inputs on the falling edge and samples outputs on a later falling edge. In a stream, the output for the sample driven at falling edge i is read at falling edge i+2. Single-pulse tests read the edges before, at and after that point. This shows the strobe is neither early nor late. The reset-cancel and hold tests read the outputs in the cycles between stimulus events, where a stale or early update would show.

// File: rtl/sigmoid_lut_pkg.sv
package sigmoid_lut_pkg;

  localparam int EXP_Q = 30;

  // Elaboration-time sample: round(2^out_frac / (1 + e^-(code / 2^frac_w))),
  // capped at the largest positive code. Integer math only.
  function automatic int sample_code(input int code, input int frac_w, input int out_frac);
    longint one, d, base, p, b, num, den, val, scale;
    int     n;
    one  = longint'(1) <<< EXP_Q;
    d    = one >>> frac_w;
    base = one - d + ((d * d) >>> (EXP_Q + 1))
           - ((((d * d) >>> EXP_Q) * d) >>> EXP_Q) / 6;
    n = (code < 0) ? -code : code;
    p = one;
    b = base;
    while (n > 0) begin
      if (n[0]) p = (p * b) >>> EXP_Q;
      b = (b * b) >>> EXP_Q;
      n = n >>> 1;
    end
    scale = longint'(1) <<< out_frac;
    num   = (code >= 0) ? one : p;
    den   = one + p;
    val   = (2 * scale * num + den) / (2 * den);
    if (val > scale - 1) val = scale - 1;
    return int'(val);
  endfunction

endpackage

// File: rtl/sigmoid_lut_addr.sv
module sigmoid_lut_addr #(
  parameter int IN_W   = 13,
  parameter int IDX_W  = 6,
  parameter int LERP_W = 6
) (
  input  logic signed [IN_W-1:0] x,
  output logic [IDX_W:0]         idx_lo,
  output logic [IDX_W:0]         idx_hi,
  output logic [LERP_W-1:0]      frac
);

  localparam int SPAN_W = IDX_W + LERP_W;
  localparam int LO_LIM = -(1 << (SPAN_W - 1));
  localparam int HI_LIM = (1 << (SPAN_W - 1)) - 1;
  localparam logic [IDX_W:0] LAST = (IDX_W + 1)'(1 << IDX_W);

  logic              below, above;
  logic [SPAN_W-1:0] offs;

  generate
    if (IN_W > SPAN_W) begin : g_sat
      assign below = (x < LO_LIM);
      assign above = (x > HI_LIM);
    end else begin : g_nosat
      assign below = 1'b0;
      assign above = 1'b0;
    end
  endgenerate

  // adding half the span flips the top bit of the in-range code
  assign offs = {~x[SPAN_W-1], x[SPAN_W-2:0]};

  always_comb begin
    if (below) begin
      idx_lo = '0;
      frac   = '0;
    end else if (above) begin
      idx_lo = LAST;
      frac   = '0;
    end else begin
      idx_lo = {1'b0, offs[SPAN_W-1:LERP_W]};
      frac   = offs[LERP_W-1:0];
    end
    idx_hi = (idx_lo == LAST) ? LAST : idx_lo + 1'b1;
  end

endmodule

// File: rtl/sigmoid_lut_rom.sv
module sigmoid_lut_rom #(
  parameter int IDX_W   = 6,
  parameter int LERP_W  = 6,
  parameter int FRAC_IN = 8,
  parameter int OUT_W   = 8
) (
  input  logic             clk,
  input  logic [IDX_W:0]   addr_a,
  input  logic [IDX_W:0]   addr_b,
  output logic [OUT_W-1:0] q_a,
  output logic [OUT_W-1:0] q_b
);

  localparam int N_ENT = (1 << IDX_W) + 1;

  logic [OUT_W-1:0] rom [N_ENT];

  generate
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
      localparam int CODE = (k - (1 << (IDX_W - 1))) * (1 << LERP_W);
      assign rom[k] = OUT_W'(sigmoid_lut_pkg::sample_code(CODE, FRAC_IN, OUT_W - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    q_a <= rom[addr_a];
    q_b <= rom[addr_b];
  end

endmodule

// File: rtl/sigmoid_lut_interp.sv
module sigmoid_lut_interp #(
  parameter int OUT_W  = 8,
  parameter int LERP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_in,
  input  logic [OUT_W-1:0]        lo,
  input  logic [OUT_W-1:0]        hi,
  input  logic [LERP_W-1:0]       frac,
  output logic                    v_out,
  output logic signed [OUT_W-1:0] y
);

  localparam int W = OUT_W + LERP_W + 2;
  localparam logic signed [W-1:0] HALF = W'(1 << (LERP_W - 1));
  localparam logic signed [W-1:0] MAXV = W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [W-1:0] MINV = -W'(1 << (OUT_W - 1));

  logic signed [OUT_W:0] diff;
  logic signed [W-1:0]   prod, step, sum;
  logic signed [OUT_W-1:0] y_nxt;

  always_comb begin
    diff = $signed({hi[OUT_W-1], hi}) - $signed({lo[OUT_W-1], lo});
    prod = diff * $signed({1'b0, frac});
    step = (prod + HALF) >>> LERP_W;
    sum  = W'($signed(lo)) + step;
    if (sum > MAXV)      y_nxt = MAXV[OUT_W-1:0];
    else if (sum < MINV) y_nxt = MINV[OUT_W-1:0];
    else                 y_nxt = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      y     <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) y <= y_nxt;
    end
  end

endmodule

// File: rtl/sigmoid_lut.sv
module sigmoid_lut #(
  parameter int IN_W    = 13,
  parameter int FRAC_IN = 8,
  parameter int IDX_W   = 6,
  parameter int LERP_W  = 6,
  parameter int OUT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  logic [IDX_W:0]    idx_lo, idx_hi;
  logic [LERP_W-1:0] frac, frac_q;
  logic [OUT_W-1:0]  t_lo, t_hi;
  logic              v1;

  sigmoid_lut_addr #(.IN_W(IN_W), .IDX_W(IDX_W), .LERP_W(LERP_W)) u_addr (
    .x(in_data), .idx_lo(idx_lo), .idx_hi(idx_hi), .frac(frac)
  );

  sigmoid_lut_rom #(.IDX_W(IDX_W), .LERP_W(LERP_W), .FRAC_IN(FRAC_IN), .OUT_W(OUT_W)) u_rom (
    .clk(clk), .addr_a(idx_lo), .addr_b(idx_hi), .q_a(t_lo), .q_b(t_hi)
  );

  // stage 1: table read alongside fraction and strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      frac_q <= '0;
    end else begin
      v1     <= in_valid;
      frac_q <= frac;
    end
  end

  // stage 2: interpolate and register the result
  sigmoid_lut_interp #(.OUT_W(OUT_W), .LERP_W(LERP_W)) u_interp (
    .clk(clk), .rst(rst), .v_in(v1), .lo(t_lo), .hi(t_hi), .frac(frac_q),
    .v_out(out_valid), .y(out_data)
  );

endmodule

// File: rtl/sigmoid_lut_chk.sv
module sigmoid_lut_chk #(
  parameter int IN_W   = 13,
  parameter int OUT_W  = 8,
  parameter int SPAN_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_data,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);

  localparam int HI_LIM = (1 << (SPAN_W - 1)) - 1;
  localparam int LO_LIM = -(1 << (SPAN_W - 1));

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid && $past(in_data, 2) > HI_LIM) |-> (out_data == ((1 << (OUT_W - 1)) - 1)));

  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid && $past(in_data, 2) < LO_LIM) |-> (out_data == 0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !out_valid) |-> $stable(out_data));

  // R7
  non_negative_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_data[OUT_W-1]);

endmodule

bind sigmoid_lut sigmoid_lut_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .SPAN_W(IDX_W + LERP_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_sigmoid_lut.sv
module test_sigmoid_lut;

  localparam int CLK_P = 10;
  localparam int IN_W  = 13;
  localparam int OUT_W = 8;
  localparam int NCODE = 1 << IN_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_data = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  sigmoid_lut i_sigmoid_lut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real ref_val(input int c);
    real x;
    x = real'(c) / 256.0;
    return 128.0 / (1.0 + $exp(-x));
  endfunction

  function automatic int ref_round(input int c);
    int e;
    e = $rtoi(ref_val(c) + 0.5);
    return (e > 127) ? 127 : e;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_data == 0, "R1", int'(out_data), 0);
    rst = 1'b0;
    // sample in flight is cancelled by a reset
    in_valid = 1'b1;
    in_data  = '0;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = '0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R2 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 due", int'(out_valid), 1);
    check(int'(out_data) == 64, "R4 x=0", int'(out_data), 64);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 late", int'(out_valid), 0);
  endtask

  task automatic t_hold;
    int exp;
    exp = ref_round(256);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 13'sd256;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = -13'sd4096;
    @(negedge clk);
    check(int'(out_data) == exp, "R4 x=1", int'(out_data), exp);
    for (int k = 0; k < 5; k++) begin
      in_data = 13'(k * 997);
      @(negedge clk);
      check(out_valid == 1'b0, "R8 strobe", int'(out_valid), 0);
      check(int'(out_data) == exp, "R8 hold", int'(out_data), exp);
    end
  endtask

  task automatic t_saturation;
    int codes[4] = '{-4096, -2049, 2048, 4095};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 13'(codes[k]);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      if (codes[k] < 0) check(int'(out_data) == 0, "R5", int'(out_data), 0);
      else              check(int'(out_data) == 127, "R6", int'(out_data), 127);
    end
  endtask

  task automatic t_sweep;
    int prev;
    prev = -1000;
    for (int i = 0; i < NCODE + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int c, got, exp;
        real r;
        c   = i - 2 - NCODE / 2;
        got = int'(out_data);
        check(out_valid == 1'b1, "R9", int'(out_valid), 1);
        if (c < -2048) begin
          check(got == 0, "R5", got, 0);
        end else if (c > 2047) begin
          check(got == 127, "R6", got, 127);
        end else begin
          r   = ref_val(c);
          exp = ref_round(c);
          check((real'(got) - r) <= 2.0 && (r - real'(got)) <= 2.0, "R3", got, exp);
          if ((c % 64) == 0) check(got == exp, "R4", got, exp);
        end
        check(got >= 0 && got >= prev, "R7", got, prev);
        prev = got;
      end
      if (i < NCODE) begin
        in_valid = 1'b1;
        in_data  = 13'(i - NCODE / 2);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_hold();
    t_saturation();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule